// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block operation (zeroing a block, cleaning or flushing a block, or invalidating a block) may proceed at the current privilege level. It receives the privilege level, a flag saying that the hart runs virtualized, the machine, hypervisor and supervisor environment-configuration registers, the operation kind, the target address and the outcome of the load and store permission probes made by the memory system. One cycle after a request strobe it reports exactly one verdict: granted, illegal-instruction trap, virtual-instruction trap or store fault. Alongside the verdict it reports the target address rounded down to the start of its cache block.

Each operation kind has its own enable field in every configuration register. The field is consulted at three tiers (machine, hypervisor, supervisor) in a fixed order, and the first tier that refuses decides which trap kind is reported. The probe inputs only matter once all permission tiers have passed. The pipeline that issues the operation, the page-table walk and the physical store of zeros stay outside this block.

Top module: `cbo_gate`

## Requirements
- R1: Operation code 0 (zero) is enabled by bit 7 of a configuration register, code 1 (clean/flush) by bit 6, code 2 (invalidate) by the two-bit field at bits 5:4, which counts as enabled when nonzero; code 3 is reserved and always yields an illegal-instruction trap at any privilege.
- R2: With privilege encoded U=0, S=1, M=3 (2 is reserved and compared numerically), a privilege value below 3 with the operation's field clear in the machine register yields an illegal-instruction trap.
- R3: When virtualized, a virtual-instruction trap results if the privilege is below 2 with the hypervisor field clear, or the privilege is below 1 with the supervisor field clear.
- R4: Without virtualization, a privilege below 1 with the supervisor field clear yields an illegal-instruction trap.
- R5: The tiers are checked in the order machine, virtual, supervisor; the first one that refuses sets the verdict.
- R6: Once all tiers pass, a zero operation is granted only if the store probe succeeds; clean, flush and invalidate are granted if either the load or the store probe succeeds; otherwise the verdict is a store fault.
- R7: The verdict appears on the clock edge after the one that samples `req_valid` high, with `done` high for that one cycle and exactly one verdict flag high; while `done` is low all verdict flags are low.
- R8: `blk_addr` is the request address with its low log2(BLOCK_BYTES) bits cleared, captured with the request and held until the next request.
- R9: Synchronous reset clears `done`, all verdict flags and `blk_addr`.
- R10: BLOCK_BYTES must be a power of two from 16 to 256; other values are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | Operation code: 0 zero, 1 clean/flush, 2 invalidate, 3 reserved |
| req_priv | input | 2 | Privilege level: 0 U, 1 S, 3 M |
| req_virt | input | 1 | Virtualization active |
| menv_cfg | input | 8 | Machine environment-configuration register |
| henv_cfg | input | 8 | Hypervisor environment-configuration register |
| senv_cfg | input | 8 | Supervisor environment-configuration register |
| req_addr | input | ADDR_W | Target address |
| load_ok | input | 1 | Load permission probe succeeded |
| store_ok | input | 1 | Store permission probe succeeded |
| done | output | 1 | Verdict valid pulse |
| grant | output | 1 | Operation permitted |
| trap_illegal | output | 1 | Illegal-instruction trap |
| trap_virtual | output | 1 | Virtual-instruction trap |
| trap_store | output | 1 | Store fault |
| blk_addr | output | ADDR_W | Address aligned down to the cache block |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples the request: the verdict flags, the `done` pulse and the aligned address all come from a single register stage. The bench drives each request on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge; it then waits one more cycle and confirms that `done` and the flags have dropped while the aligned address is held. Expected verdicts come from a bench function that applies the tier order and probe rules directly, over random requests and directed priority corners.

// File: rtl/cbo_gate_pkg.sv
package cbo_gate_pkg;

    localparam int CFG_W        = 8;
    localparam int ZERO_EN_BIT  = 7;
    localparam int CLEAN_EN_BIT = 6;
    localparam int INVAL_EN_LO  = 4;
    localparam int INVAL_EN_HI  = 5;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_t;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_INVAL = 2'd2,
        OP_RSV   = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        V_GRANT   = 2'd0,
        V_ILLEGAL = 2'd1,
        V_VIRTUAL = 2'd2,
        V_STORE   = 2'd3
    } verdict_t;

    typedef struct packed {
        logic m_en;
        logic h_en;
        logic s_en;
    } tier_en_t;

    typedef struct packed {
        logic grant;
        logic illegal;
        logic virt;
        logic store;
    } flags_t;

    function automatic logic field_enabled(input logic [CFG_W-1:0] cfg, input op_t op);
        logic en;
        case (op)
            OP_ZERO:  en = cfg[ZERO_EN_BIT];
            OP_CLEAN: en = cfg[CLEAN_EN_BIT];
            OP_INVAL: en = |cfg[INVAL_EN_HI:INVAL_EN_LO];
            default:  en = 1'b0;
        endcase
        return en;
    endfunction

    function automatic flags_t verdict_flags(input verdict_t v);
        flags_t f;
        f = '0;
        case (v)
            V_GRANT:   f.grant   = 1'b1;
            V_ILLEGAL: f.illegal = 1'b1;
            V_VIRTUAL: f.virt    = 1'b1;
            default:   f.store   = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cbo_env_lookup.sv
module cbo_env_lookup
    import cbo_gate_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  op_t              op,
    output logic             en
);
    always_comb en = field_enabled(cfg, op);
endmodule

// File: rtl/cbo_tier_rules.sv
module cbo_tier_rules
    import cbo_gate_pkg::*;
(
    input  priv_t     priv,
    input  logic      virt,
    input  op_t       op,
    input  tier_en_t  en,
    output logic      pass,
    output verdict_t  trap
);
    logic below_m, below_h, below_s;

    always_comb begin
        below_m = (priv < PRIV_M);
        below_h = (priv < PRIV_RSV);
        below_s = (priv < PRIV_S);
        pass    = 1'b0;
        trap    = V_ILLEGAL;
        if (op == OP_RSV) begin
            trap = V_ILLEGAL;
        end else if (below_m && !en.m_en) begin
            trap = V_ILLEGAL;
        end else if (virt && ((below_h && !en.h_en) || (below_s && !en.s_en))) begin
            trap = V_VIRTUAL;
        end else if (below_s && !en.s_en) begin
            trap = V_ILLEGAL;
        end else begin
            pass = 1'b1;
            trap = V_GRANT;
        end
    end
endmodule

// File: rtl/cbo_probe_select.sv
module cbo_probe_select
    import cbo_gate_pkg::*;
(
    input  op_t  op,
    input  logic load_ok,
    input  logic store_ok,
    output logic access_ok
);
    always_comb begin
        if (op == OP_ZERO) access_ok = store_ok;
        else               access_ok = load_ok || store_ok;
    end
endmodule

// File: rtl/cbo_block_align.sv
module cbo_block_align #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam logic [ADDR_W-1:0] KEEP_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

    always_comb addr_out = addr_in & KEEP_MASK;
endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
    import cbo_gate_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_priv,
    input  logic              req_virt,
    input  logic [7:0]        menv_cfg,
    input  logic [7:0]        henv_cfg,
    input  logic [7:0]        senv_cfg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              load_ok,
    input  logic              store_ok,
    output logic              done,
    output logic              grant,
    output logic              trap_illegal,
    output logic              trap_virtual,
    output logic              trap_store,
    output logic [ADDR_W-1:0] blk_addr
);
    localparam int OFF_W     = $clog2(BLOCK_BYTES);
    localparam int N_TIERS   = 3;
    localparam int TIER_M    = 2;
    localparam int TIER_H    = 1;
    localparam int TIER_S    = 0;

    initial begin
        AST_BLOCK_SIZE: assert (BLOCK_BYTES >= 16 && BLOCK_BYTES <= 256 &&
                                (BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0)
            else $error("BLOCK_BYTES must be a power of two in 16..256"); // R10
    end

    op_t   op_c;
    priv_t priv_c;
    assign op_c   = op_t'(req_op);
    assign priv_c = priv_t'(req_priv);

    logic [N_TIERS-1:0][CFG_W-1:0] cfg_set;
    logic [N_TIERS-1:0]            tier_bits;
    assign cfg_set[TIER_M] = menv_cfg;
    assign cfg_set[TIER_H] = henv_cfg;
    assign cfg_set[TIER_S] = senv_cfg;

    for (genvar t = 0; t < N_TIERS; t++) begin : g_lookup
        cbo_env_lookup u_lookup (
            .cfg (cfg_set[t]),
            .op  (op_c),
            .en  (tier_bits[t])
        );
    end

    tier_en_t tier_en;
    assign tier_en.m_en = tier_bits[TIER_M];
    assign tier_en.h_en = tier_bits[TIER_H];
    assign tier_en.s_en = tier_bits[TIER_S];

    logic     perm_pass;
    verdict_t perm_trap;
    cbo_tier_rules u_rules (
        .priv (priv_c),
        .virt (req_virt),
        .op   (op_c),
        .en   (tier_en),
        .pass (perm_pass),
        .trap (perm_trap)
    );

    logic access_ok;
    cbo_probe_select u_probe (
        .op        (op_c),
        .load_ok   (load_ok),
        .store_ok  (store_ok),
        .access_ok (access_ok)
    );

    logic [ADDR_W-1:0] aligned_c;
    cbo_block_align #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_align (
        .addr_in  (req_addr),
        .addr_out (aligned_c)
    );

    verdict_t verdict_c;
    always_comb begin
        if (!perm_pass)     verdict_c = perm_trap;
        else if (access_ok) verdict_c = V_GRANT;
        else                verdict_c = V_STORE;
    end

    flags_t            flags_q;
    logic              done_q;
    logic [ADDR_W-1:0] blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            flags_q <= '0;
            blk_q   <= '0;
        end else begin
            done_q <= req_valid;
            if (req_valid) begin
                flags_q <= verdict_flags(verdict_c);
                blk_q   <= aligned_c;
            end else begin
                flags_q <= '0;
            end
        end
    end

    assign done         = done_q;
    assign grant        = flags_q.grant;
    assign trap_illegal = flags_q.illegal;
    assign trap_virtual = flags_q.virt;
    assign trap_store   = flags_q.store;
    assign blk_addr     = blk_q;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({grant, trap_illegal, trap_virtual, trap_store}) == 1); // R7
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> $countones({grant, trap_illegal, trap_virtual, trap_store}) == 0); // R7
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done); // R7
    AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        done |-> blk_addr[OFF_W-1:0] == '0); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(blk_addr)); // R8
    AST_RSV_OP_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> trap_illegal); // R1
    AST_NO_VIRT_TRAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_virt) |=> !trap_virtual); // R3
    AST_MACHINE_NO_PERM_TRAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == 2'd3 && req_op != 2'd3) |=> !trap_illegal && !trap_virtual); // R2

endmodule

// File: tb/test_cbo_gate.sv
module test_cbo_gate;
    localparam int ADDR_W      = 32;
    localparam int BLOCK_BYTES = 64;
    localparam int WATCHDOG    = 200000;

    localparam int E_GRANT = 0;
    localparam int E_ILL   = 1;
    localparam int E_VIRT  = 2;
    localparam int E_STORE = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [1:0]        req_priv = '0;
    logic              req_virt = 1'b0;
    logic [7:0]        menv_cfg = '0;
    logic [7:0]        henv_cfg = '0;
    logic [7:0]        senv_cfg = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              load_ok = 1'b0;
    logic              store_ok = 1'b0;
    logic              done, grant, trap_illegal, trap_virtual, trap_store;
    logic [ADDR_W-1:0] blk_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cbo_gate #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) i_cbo_gate (
        .clk, .rst, .req_valid, .req_op, .req_priv, .req_virt,
        .menv_cfg, .henv_cfg, .senv_cfg, .req_addr, .load_ok, .store_ok,
        .done, .grant, .trap_illegal, .trap_virtual, .trap_store, .blk_addr
    );

    function automatic bit field_on(input logic [7:0] cfg, input logic [1:0] op);
        case (op)
            2'd0:    return cfg[7];
            2'd1:    return cfg[6];
            2'd2:    return cfg[5:4] != 2'b00;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int model(input logic [1:0] op, input logic [1:0] pv, input logic vt,
                                 input logic [7:0] m, input logic [7:0] h, input logic [7:0] s,
                                 input logic ld, input logic st);
        if (op == 2'd3) return E_ILL;
        if (pv < 2'd3 && !field_on(m, op)) return E_ILL;
        if (vt && ((pv < 2'd2 && !field_on(h, op)) || (pv < 2'd1 && !field_on(s, op)))) return E_VIRT;
        if (pv < 2'd1 && !field_on(s, op)) return E_ILL;
        if (op == 2'd0) return st ? E_GRANT : E_STORE;
        return (ld || st) ? E_GRANT : E_STORE;
    endfunction

    function automatic int observed();
        if ($countones({grant, trap_illegal, trap_virtual, trap_store}) != 1) return -1;
        if (grant)        return E_GRANT;
        if (trap_illegal) return E_ILL;
        if (trap_virtual) return E_VIRT;
        return E_STORE;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] pv, input logic vt,
                         input logic [7:0] m, input logic [7:0] h, input logic [7:0] s,
                         input logic [ADDR_W-1:0] a, input logic ld, input logic st,
                         input string tag);
        int exp_v;
        logic [ADDR_W-1:0] exp_a;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_priv = pv; req_virt = vt;
        menv_cfg = m; henv_cfg = h; senv_cfg = s; req_addr = a;
        load_ok = ld; store_ok = st;
        exp_v = model(op, pv, vt, m, h, s, ld, st);
        exp_a = a & ~ADDR_W'(BLOCK_BYTES - 1);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a;
        check(done == 1'b1, "R7 done pulse", done, 1);
        check(observed() == exp_v, tag, observed(), exp_v);
        check(blk_addr == exp_a, "R8 aligned address", blk_addr, exp_a);
        @(negedge clk);
        check(done == 1'b0 && observed() == -1 &&
              {grant, trap_illegal, trap_virtual, trap_store} == 4'b0,
              "R7 flags drop after pulse", {done, grant, trap_illegal, trap_virtual, trap_store}, 0);
        check(blk_addr == exp_a, "R8 address held", blk_addr, exp_a);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(done == 0 && grant == 0 && trap_illegal == 0 && trap_virtual == 0 &&
              trap_store == 0 && blk_addr == '0, "R9 reset outputs",
              {done, grant, trap_illegal, trap_virtual, trap_store}, 0);
        rst = 1'b0;

        // R1: field positions per op
        issue(2'd0, 2'd1, 0, 8'h80, 8'h00, 8'h00, 32'h0000_107F, 0, 1, "R1 zero uses bit 7");
        issue(2'd0, 2'd1, 0, 8'h7F, 8'h00, 8'h00, 32'h0000_1040, 0, 1, "R1 zero ignores other bits");
        issue(2'd1, 2'd1, 0, 8'h40, 8'h00, 8'h00, 32'hFFFF_FFFF, 1, 0, "R1 clean uses bit 6");
        issue(2'd2, 2'd1, 0, 8'h20, 8'h00, 8'h00, 32'h1234_5678, 1, 1, "R1 inval field value 2");
        issue(2'd2, 2'd1, 0, 8'hCF, 8'h00, 8'h00, 32'h1234_5678, 1, 1, "R1 inval field zero");
        issue(2'd3, 2'd3, 0, 8'hFF, 8'hFF, 8'hFF, 32'h0, 1, 1, "R1 reserved op at M");
        // R2: machine tier
        issue(2'd1, 2'd3, 1, 8'h00, 8'h00, 8'h00, 32'h40, 1, 0, "R2 M privilege bypasses tiers");
        issue(2'd1, 2'd2, 0, 8'h00, 8'hFF, 8'hFF, 32'h40, 1, 0, "R2 priv 2 below M");
        // R5: machine tier beats virtual tier
        issue(2'd0, 2'd0, 1, 8'h00, 8'h00, 8'h00, 32'h80, 1, 1, "R5 machine before virtual");
        // R3: virtual tier
        issue(2'd0, 2'd1, 1, 8'h80, 8'h00, 8'hFF, 32'h80, 1, 1, "R3 S virt hyp clear");
        issue(2'd0, 2'd0, 1, 8'h80, 8'h80, 8'h00, 32'h80, 1, 1, "R3 U virt sup clear");
        issue(2'd0, 2'd2, 1, 8'h80, 8'h00, 8'h00, 32'h80, 1, 1, "R3 priv 2 not below 2");
        // R4: supervisor tier
        issue(2'd0, 2'd0, 0, 8'h80, 8'h00, 8'h00, 32'h80, 1, 1, "R4 U sup clear");
        issue(2'd0, 2'd1, 0, 8'h80, 8'h00, 8'h00, 32'h80, 1, 1, "R4 S skips sup tier");
        // R6: probes
        issue(2'd0, 2'd3, 0, 8'h00, 8'h00, 8'h00, 32'hC0, 1, 0, "R6 zero needs store probe");
        issue(2'd1, 2'd3, 0, 8'h00, 8'h00, 8'h00, 32'hC0, 0, 1, "R6 clean store only");
        issue(2'd2, 2'd3, 0, 8'h00, 8'h00, 8'h00, 32'hC0, 0, 0, "R6 inval no probe");
        issue(2'd2, 2'd0, 1, 8'hFF, 8'h00, 8'hFF, 32'hC0, 0, 0, "R6 trap wins over probe");

        for (int i = 0; i < 600; i++) begin
            logic [7:0] m, h, s;
            m = 8'($urandom); h = 8'($urandom); s = 8'($urandom);
            if ($urandom_range(0, 2) == 0) m = 8'hF0;
            issue(2'($urandom), 2'($urandom), 1'($urandom), m, h, s,
                  ADDR_W'($urandom), 1'($urandom), 1'($urandom), "R5 random verdict");
        end

        // R9: reset mid-run clears outputs
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 32'hFFFF_FFC0;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(done == 0 && {grant, trap_illegal, trap_virtual, trap_store} == 4'b0 &&
              blk_addr == '0, "R9 reset clears", blk_addr, 0);
        rst = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule